// File: doc/BRIEF.md
# Lazy Thread Binder with Register Block Renaming

This block holds a pool of ready threads that belong to no processor yet. Each thread is described by nothing more than its start PC and the number of thread-local registers it uses, counted from zero as generic indices. A processor asks for work only when it would otherwise stall. At that moment the binder checks whether the thread at the head of the pool fits in that processor's register file. If it fits, the binder reserves a contiguous run of 4-register blocks and hands the thread to that processor's local queue along with the physical base of the reservation.

After that the thread belongs to that processor until it ends. When it ends, the processor reports its base and register count, and the blocks return to the free set. A small combinational rename port turns a generic index into a physical register number by adding the base, and flags indices that lie outside the thread's requested count. Threads leave the pool strictly in arrival order. A head thread that fits nowhere blocks the ones behind it.

Top module: `thread_binder`

## Requirements
- R1: Threads leave the pool in the order they were enqueued. `enq_ready` is low exactly when DEPTH threads are waiting, and an enqueue is taken only while it is high.
- R2: A thread is pushed to CPU c only in a cycle where `stall_req[c]` is high. The push shows on `push_valid[c]` in that same cycle, and the thread leaves the pool at the next clock edge.
- R3: A thread with n registers needs ceil(n/4) contiguous free 4-register blocks on the target CPU. `push_base` is 4 times the lowest block index at which such a run starts, and the reserved blocks are then in use.
- R4: If the head thread fits on no requesting CPU, nothing is pushed and the head stays unchanged. Later threads in the pool are not granted, even when they would fit.
- R5: When several requesting CPUs can take the head thread, the grant goes to the first of them at or after a rotating pointer. The pointer then moves to the winner plus one, modulo NCPU. It is 0 after reset.
- R6: At most one bit of `push_valid` is high in any cycle.
- R7: `kill_valid[c]` with `kill_base` and `kill_nregs` frees the blocks those values cover on CPU c at the next clock edge. In the cycle of the kill itself they still count as used.
- R8: `ren_phys` equals `ren_base + ren_idx`. `ren_ok` is high exactly when `ren_idx < ren_nregs`.
- R9: After reset the pool is empty, `enq_ready` is high, every register block is free and no push is made even with stall requests present.
- R10: A thread that asks for zero registers always fits and is pushed with base 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | A new ready thread is offered to the pool |
| enq_pc | input | PC_W | Start PC of the offered thread |
| enq_nregs | input | NREG_W | Generic register count of the offered thread |
| enq_ready | output | 1 | Pool can accept a thread this cycle |
| stall_req | input | NCPU | Per-CPU request for work, held until granted |
| push_valid | output | NCPU | Per-CPU push into the local queue |
| push_pc | output | PC_W | Start PC of the pushed thread |
| push_nregs | output | NREG_W | Register count of the pushed thread |
| push_base | output | BASE_W | Physical register base reserved for it |
| kill_valid | input | NCPU | Per-CPU thread termination |
| kill_base | input | NCPU*BASE_W | Per-CPU base of the ending thread |
| kill_nregs | input | NCPU*NREG_W | Per-CPU register count of the ending thread |
| ren_base | input | BASE_W | Rename lookup: physical base |
| ren_nregs | input | NREG_W | Rename lookup: requested count |
| ren_idx | input | BASE_W | Rename lookup: generic index |
| ren_phys | output | BASE_W | Physical register number |
| ren_ok | output | 1 | Generic index lies inside the requested count |

## Verification
The checker watches several properties on every cycle. It confirms that at most one push happens and only to a requesting CPU, that each granted run is aligned and was free before the grant, and that a killed run is free one edge later. It also checks that an ungranted head stays put and that a valid rename lands inside the thread's window. Other behaviour needs the directed scenarios: the round-robin choice between two CPUs that both fit, lowest-fit placement into a hole left by a kill, the zero-register thread, pool order and the full flag. The bench also shows that a smaller thread queued behind a blocked head is held back.

// File: rtl/tbind_pkg.sv
`timescale 1ns/1ps
package tbind_pkg;
    localparam int PC_W   = 16;
    localparam int REGS   = 32;
    localparam int BLK    = 4;
    localparam int NBLK   = REGS / BLK;
    localparam int NREG_W = $clog2(REGS + 1);
    localparam int BASE_W = $clog2(REGS);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [NREG_W-1:0] nregs;
    } thread_t;

    // Block mask covering [base, base+n) rounded out to whole blocks
    function automatic logic [NBLK-1:0] blk_mask(input logic [BASE_W-1:0] base,
                                                 input logic [NREG_W-1:0] n);
        int nb;
        int sb;
        logic [2*NBLK-1:0] w;
        nb = (int'(n) + BLK - 1) / BLK;
        sb = int'(base) / BLK;
        w  = ((2*NBLK)'(1) << nb) - (2*NBLK)'(1);
        w  = w << sb;
        return w[NBLK-1:0];
    endfunction
endpackage

// File: rtl/tbind_pool.sv
`timescale 1ns/1ps
module tbind_pool
    import tbind_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    input  thread_t in_thread,
    output logic    in_ready,
    input  logic    pop,
    output logic    head_valid,
    output thread_t head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        thread_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]    wr;
        logic [PTR_W-1:0]    rd;
        logic [CNT_W-1:0]    cnt;
    } pool_t;

    pool_t st_d, st_q;
    logic  do_push, do_pop;

    assign in_ready   = (st_q.cnt != CNT_W'(DEPTH));
    assign head_valid = (st_q.cnt != '0);
    assign head       = st_q.mem[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_push = in_valid && in_ready;
        do_pop  = pop && head_valid;
        if (do_push) begin
            st_d.mem[st_q.wr] = in_thread;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tbind_fit.sv
`timescale 1ns/1ps
module tbind_fit
    import tbind_pkg::*;
(
    input  logic [NBLK-1:0]   used,
    input  logic [NREG_W-1:0] nregs,
    output logic              fit,
    output logic [BASE_W-1:0] base,
    output logic [NBLK-1:0]   mask
);
    // Descending scan so the lowest fitting start is the one kept
    always_comb begin
        fit  = 1'b0;
        base = '0;
        mask = '0;
        for (int s = NBLK - 1; s >= 0; s--) begin
            logic [NBLK-1:0] m;
            m = blk_mask(BASE_W'(s * BLK), nregs);
            if ((s * BLK + int'(nregs) <= REGS) && ((m & used) == '0)) begin
                fit  = 1'b1;
                base = BASE_W'(s * BLK);
                mask = m;
            end
        end
    end
endmodule

// File: rtl/tbind_rename.sv
`timescale 1ns/1ps
module tbind_rename
    import tbind_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic [NREG_W-1:0] nregs,
    input  logic [BASE_W-1:0] idx,
    output logic [BASE_W-1:0] phys,
    output logic              ok
);
    assign phys = base + idx;
    assign ok   = (NREG_W'(idx) < nregs);
endmodule

// File: rtl/thread_binder.sv
`timescale 1ns/1ps
module thread_binder
    import tbind_pkg::*;
#(
    parameter int NCPU  = 2,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enq_valid,
    input  logic [PC_W-1:0]          enq_pc,
    input  logic [NREG_W-1:0]        enq_nregs,
    output logic                     enq_ready,
    input  logic [NCPU-1:0]          stall_req,
    output logic [NCPU-1:0]          push_valid,
    output logic [PC_W-1:0]          push_pc,
    output logic [NREG_W-1:0]        push_nregs,
    output logic [BASE_W-1:0]        push_base,
    input  logic [NCPU-1:0]          kill_valid,
    input  logic [NCPU*BASE_W-1:0]   kill_base,
    input  logic [NCPU*NREG_W-1:0]   kill_nregs,
    input  logic [BASE_W-1:0]        ren_base,
    input  logic [NREG_W-1:0]        ren_nregs,
    input  logic [BASE_W-1:0]        ren_idx,
    output logic [BASE_W-1:0]        ren_phys,
    output logic                     ren_ok
);
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    typedef struct packed {
        logic [NCPU-1:0][NBLK-1:0] used;
        logic [CPU_W-1:0]          rr;
    } bind_t;

    bind_t   st_d, st_q;
    thread_t head;
    logic    head_valid;
    logic    pool_pop;
    logic    found;
    int      win;
    logic [NCPU*NBLK-1:0]     used_flat;
    logic [NCPU-1:0]          fit;
    logic [NCPU-1:0]          cand;
    logic [NBLK-1:0]          fit_mask [NCPU];
    logic [BASE_W-1:0]        fit_base [NCPU];

    assign used_flat = st_q.used;

    tbind_pool #(.DEPTH(DEPTH)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (enq_valid),
        .in_thread  ({enq_pc, enq_nregs}),
        .in_ready   (enq_ready),
        .pop        (pool_pop),
        .head_valid (head_valid),
        .head       (head)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        tbind_fit u_fit (
            .used  (st_q.used[c]),
            .nregs (head.nregs),
            .fit   (fit[c]),
            .base  (fit_base[c]),
            .mask  (fit_mask[c])
        );
        assign cand[c] = stall_req[c] && fit[c] && head_valid;
    end

    tbind_rename u_ren (
        .base  (ren_base),
        .nregs (ren_nregs),
        .idx   (ren_idx),
        .phys  (ren_phys),
        .ok    (ren_ok)
    );

    // Round-robin pick among requesting CPUs that can hold the head
    always_comb begin
        found = 1'b0;
        win   = 0;
        for (int i = 0; i < NCPU; i++) begin
            automatic int cidx = (int'(st_q.rr) + i) % NCPU;
            if (!found && cand[cidx]) begin
                found = 1'b1;
                win   = cidx;
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        push_valid = '0;
        push_valid[win] = found;
        pool_pop   = found;
        push_pc    = head.pc;
        push_nregs = head.nregs;
        push_base  = fit_base[win];
        for (int c = 0; c < NCPU; c++) begin
            logic [NBLK-1:0] set_m;
            logic [NBLK-1:0] clr_m;
            set_m = (found && win == c) ? fit_mask[c] : '0;
            clr_m = kill_valid[c] ? blk_mask(kill_base[c*BASE_W +: BASE_W],
                                             kill_nregs[c*NREG_W +: NREG_W]) : '0;
            st_d.used[c] = (st_q.used[c] | set_m) & ~clr_m;
        end
        if (found) st_d.rr = CPU_W'((win + 1) % NCPU);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/thread_binder_chk.sv
`timescale 1ns/1ps
module thread_binder_chk
    import tbind_pkg::*;
#(
    parameter int NCPU = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCPU-1:0]        stall_req,
    input logic [NCPU-1:0]        push_valid,
    input logic [NREG_W-1:0]      push_nregs,
    input logic [BASE_W-1:0]      push_base,
    input logic [NCPU-1:0]        kill_valid,
    input logic [NCPU*BASE_W-1:0] kill_base,
    input logic [NCPU*NREG_W-1:0] kill_nregs,
    input logic [NCPU*NBLK-1:0]   used_flat,
    input logic                   head_valid,
    input thread_t                head,
    input logic                   pool_pop,
    input logic [BASE_W-1:0]      ren_base,
    input logic [NREG_W-1:0]      ren_nregs,
    input logic [BASE_W-1:0]      ren_phys,
    input logic                   ren_ok
);
    AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_valid)); // R6

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid != '0) |-> (int'(push_base) % BLK == 0)); // R3

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !pool_pop) |=> (head_valid && head == $past(head))); // R4

    AST_REN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ren_ok |-> (NREG_W'(ren_phys - ren_base) < ren_nregs)); // R8

    for (genvar c = 0; c < NCPU; c++) begin : g_chk
        AST_PUSH_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
            push_valid[c] |-> stall_req[c]); // R2

        AST_PUSH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            push_valid[c] |-> ((blk_mask(push_base, push_nregs)
                                & used_flat[c*NBLK +: NBLK]) == '0)); // R3

        AST_KILL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            kill_valid[c] |=> ((blk_mask($past(kill_base[c*BASE_W +: BASE_W]),
                                         $past(kill_nregs[c*NREG_W +: NREG_W]))
                                & used_flat[c*NBLK +: NBLK]) == '0)); // R7
    end
endmodule

bind thread_binder thread_binder_chk #(.NCPU(NCPU)) u_chk (.*);

// File: tb/thread_binder_bench.sv
`timescale 1ns/1ps
module thread_binder_bench;
    import tbind_pkg::*;

    localparam int NCPU = 2;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   enq_valid = 1'b0;
    logic [PC_W-1:0]        enq_pc = '0;
    logic [NREG_W-1:0]      enq_nregs = '0;
    logic                   enq_ready;
    logic [NCPU-1:0]        stall_req = '0;
    logic [NCPU-1:0]        push_valid;
    logic [PC_W-1:0]        push_pc;
    logic [NREG_W-1:0]      push_nregs;
    logic [BASE_W-1:0]      push_base;
    logic [NCPU-1:0]        kill_valid = '0;
    logic [NCPU*BASE_W-1:0] kill_base = '0;
    logic [NCPU*NREG_W-1:0] kill_nregs = '0;
    logic [BASE_W-1:0]      ren_base = '0;
    logic [NREG_W-1:0]      ren_nregs = '0;
    logic [BASE_W-1:0]      ren_idx = '0;
    logic [BASE_W-1:0]      ren_phys;
    logic                   ren_ok;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    thread_binder #(.NCPU(NCPU), .DEPTH(4)) u_thread_binder (.*);

    // rename vectors: base, nregs, idx, expected phys, expected ok
    localparam int NVEC = 6;
    localparam logic [21:0] REN_VEC [NVEC] = '{
        {5'd0,  6'd4,  5'd3,  5'd3,  1'b1},
        {5'd8,  6'd4,  5'd4,  5'd12, 1'b0},
        {5'd28, 6'd4,  5'd3,  5'd31, 1'b1},
        {5'd4,  6'd0,  5'd0,  5'd4,  1'b0},
        {5'd16, 6'd16, 5'd15, 5'd31, 1'b1},
        {5'd12, 6'd8,  5'd8,  5'd20, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic enq(input logic [PC_W-1:0] pc, input logic [NREG_W-1:0] n);
        enq_valid = 1'b1;
        enq_pc    = pc;
        enq_nregs = n;
        tick();
        enq_valid = 1'b0;
    endtask

    // request work, check the push in that cycle, then drop the request after the edge
    task automatic grant(input logic [NCPU-1:0] req, input logic [NCPU-1:0] exp_v,
                         input logic [PC_W-1:0] exp_pc, input logic [BASE_W-1:0] exp_base,
                         input string tag);
        stall_req = req;
        @(negedge clk);
        chk({tag, " push_valid"}, 32'(push_valid), 32'(exp_v));
        if (exp_v != '0) begin
            chk({tag, " push_pc"}, 32'(push_pc), 32'(exp_pc));
            chk({tag, " push_base"}, 32'(push_base), 32'(exp_base));
        end
        tick();
        stall_req = '0;
    endtask

    task automatic kill(input int cpu, input logic [BASE_W-1:0] b, input logic [NREG_W-1:0] n);
        kill_valid = '0;
        kill_valid[cpu] = 1'b1;
        kill_base[cpu*BASE_W +: BASE_W]   = b;
        kill_nregs[cpu*NREG_W +: NREG_W] = n;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // rename table walk (R8)
        for (int i = 0; i < NVEC; i++) begin
            ren_base  = REN_VEC[i][21:17];
            ren_nregs = REN_VEC[i][16:11];
            ren_idx   = REN_VEC[i][10:6];
            #1;
            chk("R8 ren_phys", 32'(ren_phys), 32'(REN_VEC[i][5:1]));
            chk("R8 ren_ok", 32'(ren_ok), 32'(REN_VEC[i][0]));
        end

        tick();
        tick();
        rst_n = 1'b1;
        tick();

        // R9: reset state, requests with an empty pool give nothing
        stall_req = 2'b11;
        @(negedge clk);
        chk("R9 enq_ready", 32'(enq_ready), 32'd1);
        chk("R9 no push", 32'(push_valid), 32'd0);
        tick();
        stall_req = '0;

        // R1: fill the pool
        enq(16'h0100, 6'd5);
        enq(16'h0200, 6'd8);
        enq(16'h0300, 6'd32);
        enq(16'h0400, 6'd4);
        @(negedge clk);
        chk("R1 full", 32'(enq_ready), 32'd0);
        chk("R2 no request no push", 32'(push_valid), 32'd0);
        tick();

        // R2, R3: first thread to CPU0 at base 0
        grant(2'b01, 2'b01, 16'h0100, 5'd0, "R2");
        @(negedge clk);
        chk("R1 space after pop", 32'(enq_ready), 32'd1);
        tick();

        // R5, R6: pointer now at CPU1, both fit
        grant(2'b11, 2'b10, 16'h0200, 5'd0, "R5 R6");

        // R4: 32-register head fits nowhere, smaller thread behind is held
        grant(2'b01, 2'b00, 16'h0, 5'd0, "R4 cpu0");
        grant(2'b11, 2'b00, 16'h0, 5'd0, "R4 both");

        // R7: kill on CPU0, still used in the kill cycle
        kill(0, 5'd0, 6'd5);
        stall_req = 2'b01;
        @(negedge clk);
        chk("R7 kill cycle", 32'(push_valid), 32'd0);
        tick();
        kill_valid = '0;
        grant(2'b01, 2'b01, 16'h0300, 5'd0, "R7 after kill");

        // R3: CPU0 full, CPU1 lowest free block is 2
        grant(2'b11, 2'b10, 16'h0400, 5'd8, "R3 lowest fit");

        // R10: zero registers, pointer at CPU0
        enq(16'h0500, 6'd0);
        enq(16'h0600, 6'd4);
        grant(2'b11, 2'b01, 16'h0500, 5'd0, "R10 zero regs");
        grant(2'b11, 2'b10, 16'h0600, 5'd12, "R3 cpu1 next");

        // R7, R3: hole in the middle of CPU1 reused
        kill(1, 5'd8, 6'd4);
        tick();
        kill_valid = '0;
        enq(16'h0700, 6'd3);
        grant(2'b10, 2'b10, 16'h0700, 5'd8, "R7 hole reuse");
        @(negedge clk);
        chk("R1 pool drained", 32'(push_valid), 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule